// File: doc/BRIEF.md
# Flash Controller Interrupt Status and Mask Register

This block keeps the event status of a flash memory controller and turns it into one interrupt line. It has thirteen status bits. Each bit is set by a one-cycle pulse from the logic that detects its event, and it then stays set. Twelve of the bits are cleared by the host, which writes a 1 to each bit it has serviced. The top bit reports that the controller is idle. The host cannot clear it or mask it. The next command start clears it.

A twelve-bit mask sits beside the status. A mask bit at 1 blocks its status bit from the interrupt, so reset leaves every source blocked. When the controller clock is stopped and started again, the status register is loaded with a fixed value that shows both ready bits set. The host reaches the status and the mask through one small register port. A select line picks the register, a write strobe updates it, and the read data is registered.

Top module: `flash_irq_regs`

## Requirements
- R1: After reset the status register reads 0x0000, the mask reads 0xFFF and irq_o is 0.
- R2: A pulse on evt_i[n] sets status bit n at the next clock edge, and the bit stays set with no further pulse. Bit positions: 0 command-buffer request, 1 read-data request, 2 write-data request, 3 correctable ECC error, 4 uncorrectable ECC error, 5 bad block on chip select 1, 6 bad block on chip select 0, 7 command done on chip select 1, 8 command done on chip select 0, 9 page done on chip select 1, 10 page done on chip select 0, 11 flash ready, 12 controller ready.
- R3: A write with reg_sel_i = 0 clears each status bit in 11:0 whose reg_wdata_i bit is 1. Bits written as 0 keep their value.
- R4: Writing 0xFFF to the status clears all of bits 11:0 in one write and leaves bit 12 unchanged.
- R5: A write with reg_sel_i = 1 loads the mask from reg_wdata_i. A mask bit at 1 blocks its status bit. irq_o is 1 exactly when some status bit n in 11:0 is set and mask bit n is 0. irq_o follows the state with one clock of latency.
- R6: If an event pulse and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R7: Status bit 12 never drives irq_o. Host writes do not clear it. cmd_start_i clears it, unless evt_i[12] pulses in the same cycle, in which case it stays set.
- R8: A pulse on clk_restart_i loads the status with 0x1800 (bits 11 and 12 set, all others clear). It overrides any event or clear in that cycle. A mask write in that cycle still takes effect.
- R9: reg_rdata_o shows, one clock after the select is applied, the status (reg_sel_i = 0) or the mask (reg_sel_i = 1), zero-extended to the port width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 13 | One-cycle event pulses, one per status bit |
| cmd_start_i | input | 1 | Command start pulse; clears status bit 12 |
| clk_restart_i | input | 1 | Pulse that marks a controller clock restart |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 12 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two pairs of actions can fall in the same clock cycle. An event pulse can arrive while the host writes 1 to clear that same bit. A command start can arrive while the controller-ready event pulses. The bench drives each pair on one edge. It then reads the status back one cycle later and expects the bit still set. A clock-restart pulse is also applied while an event is pending and a mask write is under way, and the bench expects 0x1800 together with the new mask.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int SRC_CNT = 12;
  localparam int BIT_CMD_REQ   = 0;
  localparam int BIT_RD_REQ    = 1;
  localparam int BIT_WR_REQ    = 2;
  localparam int BIT_ECC_FIX   = 3;
  localparam int BIT_ECC_FAIL  = 4;
  localparam int BIT_BAD_CS1   = 5;
  localparam int BIT_BAD_CS0   = 6;
  localparam int BIT_DONE_CS1  = 7;
  localparam int BIT_DONE_CS0  = 8;
  localparam int BIT_PAGE_CS1  = 9;
  localparam int BIT_PAGE_CS0  = 10;
  localparam int BIT_FLASH_RDY = 11;
  localparam int BIT_CTRL_RDY  = 12;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/flash_irq_status.sv
module flash_irq_status #(
  parameter int NUM_SRC = 12,
  parameter logic [NUM_SRC:0] RESTART_VAL = 13'h1800
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:0]   evt,
  input  logic               cmd_start,
  input  logic               restart,
  input  logic               wr_stat,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC:0]   status
);
  logic [NUM_SRC-1:0] clr;

  assign clr = wr_stat ? wdata : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)
        status[i] <= 1'b0;
      else if (restart)
        status[i] <= RESTART_VAL[i];
      else
        status[i] <= evt[i] | (status[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      status[NUM_SRC] <= 1'b0;
    else if (restart)
      status[NUM_SRC] <= RESTART_VAL[NUM_SRC];
    else
      status[NUM_SRC] <= evt[NUM_SRC] | (status[NUM_SRC] & ~cmd_start);
  end
endmodule

// File: rtl/flash_irq_mask.sv
module flash_irq_mask #(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_mask,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)
      mask <= '1;
    else if (wr_mask)
      mask <= wdata;
  end
endmodule

// File: rtl/flash_irq_out.sv
module flash_irq_out #(
  parameter int NUM_SRC = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic [NUM_SRC:0]   status,
  input  logic [NUM_SRC-1:0] mask,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  localparam int STAT_W = NUM_SRC + 1;

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (sel == flash_irq_pkg::SEL_MASK)
      rd_next[NUM_SRC-1:0] = mask;
    else
      rd_next[STAT_W-1:0] = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= rd_next;
      irq   <= |(status[NUM_SRC-1:0] & ~mask);
    end
  end
endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs #(
  parameter int NUM_SRC = flash_irq_pkg::SRC_CNT,
  parameter int DATA_W  = 32,
  parameter logic [NUM_SRC:0] RESTART_VAL = 13'h1800
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:0]   evt_i,
  input  logic               cmd_start_i,
  input  logic               clk_restart_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC:0]   status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               wr_stat;
  logic               wr_mask;

  assign wr_stat = reg_wr_i && (reg_sel_i == flash_irq_pkg::SEL_STATUS);
  assign wr_mask = reg_wr_i && (reg_sel_i == flash_irq_pkg::SEL_MASK);

  flash_irq_status #(.NUM_SRC(NUM_SRC), .RESTART_VAL(RESTART_VAL)) u_status (
    .clk(clk), .rst(rst), .evt(evt_i), .cmd_start(cmd_start_i),
    .restart(clk_restart_i), .wr_stat(wr_stat), .wdata(reg_wdata_i),
    .status(status_q)
  );

  flash_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .wdata(reg_wdata_i),
    .mask(mask_q)
  );

  flash_irq_out #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .sel(reg_sel_i), .status(status_q),
    .mask(mask_q), .rdata(reg_rdata_o), .irq(irq_o)
  );
endmodule

// File: rtl/flash_irq_regs_chk.sv
module flash_irq_regs_chk #(
  parameter int NUM_SRC = 12,
  parameter logic [NUM_SRC:0] RESTART_VAL = 13'h1800
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC:0]   evt_i,
  input logic               cmd_start_i,
  input logic               clk_restart_i,
  input logic               reg_wr_i,
  input logic               reg_sel_i,
  input logic [NUM_SRC-1:0] reg_wdata_i,
  input logic [NUM_SRC:0]   status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq_o
);
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    !clk_restart_i |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    !clk_restart_i |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0)); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && !reg_sel_i && !clk_restart_i) |=>
    ((status_q[NUM_SRC-1:0] & $past(reg_wdata_i & ~evt_i[NUM_SRC-1:0])) == '0)); // R3

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((status_q[NUM_SRC-1:0] & ~mask_q) == '0) |=> !irq_o); // R5

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (status_q[NUM_SRC] && !cmd_start_i && !clk_restart_i) |=> status_q[NUM_SRC]); // R7

  AST_RESTART_VAL: assert property (@(posedge clk) disable iff (rst)
    clk_restart_i |=> (status_q == RESTART_VAL)); // R8
endmodule

bind flash_irq_regs flash_irq_regs_chk #(.NUM_SRC(NUM_SRC), .RESTART_VAL(RESTART_VAL)) i_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .cmd_start_i(cmd_start_i),
  .clk_restart_i(clk_restart_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
  .reg_wdata_i(reg_wdata_i), .status_q(status_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/test_flash_irq_regs.sv
`timescale 1ns/1ps
module test_flash_irq_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] evt_i = '0;
  logic        cmd_start_i = 1'b0;
  logic        clk_restart_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic        reg_sel_i = 1'b0;
  logic [11:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [12:0] m_stat;
  logic [11:0] m_mask;

  string       tag_q[$];
  logic [31:0] rd_q[$];
  logic        irq_q[$];
  event        sample_ev;

  always #2.5 clk = ~clk;

  flash_irq_regs i_flash_irq_regs (
    .clk(clk), .rst(rst), .evt_i(evt_i), .cmd_start_i(cmd_start_i),
    .clk_restart_i(clk_restart_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(sample_ev);
      while (tag_q.size() > 0) begin
        string t;
        logic [31:0] er;
        logic ei;
        t  = tag_q.pop_front();
        er = rd_q.pop_front();
        ei = irq_q.pop_front();
        checks++;
        if (reg_rdata_o !== er || irq_o !== ei) begin
          errors++;
          $display("FAIL %s rdata=%h irq=%b expected rdata=%h irq=%b",
                   t, reg_rdata_o, irq_o, er, ei);
        end
      end
    end
  end

  // driver: one operation, model update, then read back through rsel
  task automatic op(input logic [12:0] evt, input logic wr, input logic sel,
                    input logic [11:0] wd, input logic start, input logic rstrt,
                    input logic rsel, input string tag);
    logic [11:0] clr;
    @(negedge clk);
    evt_i = evt; reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd;
    cmd_start_i = start; clk_restart_i = rstrt;
    clr = (wr && !sel) ? wd : 12'h000;
    if (rstrt)
      m_stat = 13'h1800;
    else begin
      m_stat[11:0] = evt[11:0] | (m_stat[11:0] & ~clr);
      m_stat[12]   = evt[12] | (m_stat[12] & ~start);
    end
    if (wr && sel) m_mask = wd;
    @(negedge clk);
    evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    cmd_start_i = 1'b0; clk_restart_i = 1'b0; reg_sel_i = rsel;
    @(negedge clk);
    tag_q.push_back(tag);
    rd_q.push_back(rsel ? {20'h0, m_mask} : {19'h0, m_stat});
    irq_q.push_back(|(m_stat[11:0] & ~m_mask));
    -> sample_ev;
  endtask

  initial begin
    m_stat = '0;
    m_mask = 12'hFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    op(13'h0, 0, 0, 12'h0, 0, 0, 0, "R1 status after reset");
    op(13'h0, 0, 0, 12'h0, 0, 0, 1, "R1 mask after reset");
    // R2 event sets and holds, masked so no irq
    op(13'h0008, 0, 0, 12'h0, 0, 0, 0, "R2 event sets bit 3");
    op(13'h0, 0, 0, 12'h0, 0, 0, 0, "R2 bit 3 holds");
    // R5 unmask bit 3
    op(13'h0, 1, 1, 12'hFF7, 0, 0, 0, "R5 unmask raises irq");
    op(13'h0, 0, 0, 12'h0, 0, 0, 1, "R9 mask readback");
    // R3 write zero, then write one
    op(13'h0, 1, 0, 12'h000, 0, 0, 0, "R3 write 0 keeps bit");
    op(13'h0, 1, 0, 12'h008, 0, 0, 0, "R3 write 1 clears bit");
    // R6 same-cycle set and clear
    op(13'h0008, 1, 0, 12'h008, 0, 0, 0, "R6 event wins over clear");
    // R5 masked source does not raise irq
    op(13'h0, 1, 1, 12'hFFF, 0, 0, 0, "R5 masking drops irq");
    // R4 clear all low bits, bit 12 kept
    op(13'h1127, 0, 0, 12'h0, 0, 0, 0, "R4 several events set");
    op(13'h0, 1, 0, 12'hFFF, 0, 0, 0, "R4 clear all keeps bit 12");
    // R7 bit 12 not in irq, cleared by command start
    op(13'h0, 1, 1, 12'h000, 0, 0, 0, "R7 bit 12 not maskable source");
    op(13'h1000, 0, 0, 12'h0, 1, 0, 0, "R7 event beats command start");
    op(13'h0, 0, 0, 12'h0, 1, 0, 0, "R7 command start clears bit 12");
    // R8 restart with pending event and mask write
    op(13'h0001, 0, 0, 12'h0, 0, 0, 0, "R5 unmasked bit 0 raises irq");
    op(13'h0004, 1, 1, 12'h7FF, 0, 1, 0, "R8 restart loads 0x1800");
    op(13'h0, 0, 0, 12'h0, 0, 0, 1, "R8 mask write during restart");
    op(13'h0, 1, 1, 12'h000, 0, 0, 0, "R8 flash ready bit drives irq");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule